// File: doc/BRIEF.md
# One-Level Pyramid Residual Generator

This block computes one level of a one-dimensional Laplacian pyramid on a raster stream of 8-bit pixels. Each line is smoothed and halved to give a stream of low-band coefficients. Those coefficients are expanded back to full rate as a prediction of the line. The prediction is then subtracted from the original pixels, which gives a signed high-band residual for every input sample.

The original pixels travel through a fixed-length alignment delay line. Each pixel therefore reaches the subtractor in the same cycle as its prediction. Lines may be sent back to back. A line-start mark travels with the data, so every filter stage clears its own history exactly when the new line reaches it. Nothing has to be drained between lines, and the residual stream keeps one result per cycle across line boundaries.

Within a line, samples must arrive on consecutive cycles, and each line holds an even number of samples. Idle cycles are allowed between lines.

Top module: `pyr_residual_level`

## Requirements
- R1: For the pair of samples n=2k and n=2k+1 of a line, the low-band coefficient is q[k] = (x[2k+1] + 2*x[2k] + x[2k-1] + 2) >> 2. Samples before the line start count as zero. The coefficient appears on `lo_coef` with `lo_valid` high, two clock edges after the edge that captures x[2k+1].
- R2: `lo_valid` is never high in two consecutive cycles. A line of L samples yields exactly L/2 coefficients.
- R3: The prediction of the odd sample 2k+1 is q[k]. The prediction of the even sample 2k is (q[k-1] + q[k] + 1) >> 1, and for the first pair of a line it is q[0].
- R4: The residual is x[n] minus its prediction, given as a 12-bit two's-complement value without saturation. It always lies in -255..255.
- R5: The residual for a sample captured at clock edge E appears on `hf_resid` with `hf_valid` high at edge E+10 (parameter ALIGN_DEPTH).
- R6: The alignment depth equals the prediction-path latency, ALIGN_DEPTH = 5 + PRED_STAGES. An aligned pixel and its prediction always reach the subtractor in the same cycle.
- R7: A sample with `in_valid` and `in_line_start` both high clears all filter histories. No output of a line depends on samples of an earlier line.
- R8: Lines sent back to back produce residuals on consecutive cycles, with no idle cycle at the line boundary.
- R9: While and right after the synchronous reset, `lo_valid` and `hf_valid` are low.
- R10: Cycles with `in_valid` low, whatever `in_line_start` and `in_pixel` hold, produce no output and change no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Input pixel present this cycle |
| in_line_start | input | 1 | Marks the first pixel of a line (used only with in_valid) |
| in_pixel | input | 8 | Unsigned input pixel |
| lo_valid | output | 1 | Low-band coefficient present |
| lo_coef | output | 8 | Low-band coefficient, half rate |
| hf_valid | output | 1 | Residual present |
| hf_resid | output | 12 | Signed residual, full rate |

## Verification
The hardest situation to reach is a line boundary where the new line enters the filters while the tail of the previous line is still in the interpolator and the alignment line. The line-start mark has to clear each stage's history at a different cycle, and the residual stream must not pause. The stimulus sends groups of lines with no idle cycle between them, including a two-sample line and a line whose predecessor ends on extreme values. The model assumes zero history, so any leak across the boundary shows up as a value mismatch. Any stall shows up both as a timing mismatch and as a shorter run of consecutive residuals.

// File: rtl/pyr_lvl_pkg.sv
package pyr_lvl_pkg;

    localparam int PIX_W = 8;
    localparam int DEC_W = 10;
    localparam int RES_W = 12;

    typedef logic [PIX_W-1:0]        pix_t;
    typedef logic [DEC_W-1:0]        dsum_t;
    typedef logic signed [RES_W-1:0] res_t;

    // input sample carried with its line tag
    typedef struct packed {
        logic valid;
        logic first;
        pix_t pix;
    } samp_t;

    // low-band coefficient with line tag
    typedef struct packed {
        logic valid;
        logic first;
        pix_t coef;
    } band_t;

    // plain valid + pixel word (prediction, aligned original)
    typedef struct packed {
        logic valid;
        pix_t pix;
    } word_t;

    // (d + 2) >> 2, d at most 1020
    function automatic pix_t round_quarter(dsum_t d);
        logic [DEC_W:0] t;
        t = {1'b0, d} + (DEC_W+1)'(2);
        return t[DEC_W-1:2];
    endfunction

    // (a + b + 1) >> 1
    function automatic pix_t mid_up(pix_t a, pix_t b);
        logic [PIX_W:0] t;
        t = {1'b0, a} + {1'b0, b} + (PIX_W+1)'(1);
        return t[PIX_W:1];
    endfunction

    function automatic res_t diff_of(pix_t x, pix_t p);
        return $signed({{(RES_W-PIX_W){1'b0}}, x}) - $signed({{(RES_W-PIX_W){1'b0}}, p});
    endfunction

endpackage

// File: rtl/pyr_lvl_decim.sv
module pyr_lvl_decim
    import pyr_lvl_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  in_valid,
    input  logic  in_line_start,
    input  pix_t  in_pixel,
    output band_t band
);

    samp_t a_s;
    logic  a_odd;
    logic  phase;

    // stage A: capture and pair phase
    always_ff @(posedge clk) begin
        if (rst) begin
            a_s   <= '0;
            a_odd <= 1'b0;
            phase <= 1'b0;
        end else begin
            a_s.valid <= in_valid;
            a_s.first <= in_valid & in_line_start;
            a_s.pix   <= in_pixel;
            if (in_valid) begin
                if (in_line_start) begin
                    a_odd <= 1'b0;
                    phase <= 1'b1;
                end else begin
                    a_odd <= phase;
                    phase <= ~phase;
                end
            end
        end
    end

    pix_t  h1, h2;
    logic  pair_first;
    logic  b_valid, b_first;
    dsum_t b_sum;

    // stage B: [1 2 1] smoothing, kept only on odd samples
    always_ff @(posedge clk) begin
        if (rst) begin
            h1         <= '0;
            h2         <= '0;
            pair_first <= 1'b0;
            b_valid    <= 1'b0;
            b_first    <= 1'b0;
            b_sum      <= '0;
        end else begin
            b_valid <= a_s.valid & a_odd;
            if (a_s.valid) begin
                h1 <= a_s.pix;
                if (a_s.first) begin
                    h2         <= '0;
                    pair_first <= 1'b1;
                end else begin
                    h2 <= h1;
                end
                if (a_odd) begin
                    b_sum      <= dsum_t'(a_s.pix) + (dsum_t'(h1) << 1) + dsum_t'(h2);
                    b_first    <= pair_first;
                    pair_first <= 1'b0;
                end
            end
        end
    end

    // stage C: rounding to the output coefficient
    always_ff @(posedge clk) begin
        if (rst) begin
            band <= '0;
        end else begin
            band.valid <= b_valid;
            band.first <= b_first;
            band.coef  <= round_quarter(b_sum);
        end
    end

    // one coefficient per sample pair
    assert_half_rate_R2: assert property (@(posedge clk) disable iff (rst)
        b_valid |=> !b_valid);

    // a first sample can never be the odd one of a pair
    assert_first_even_R7: assert property (@(posedge clk) disable iff (rst)
        (a_s.valid && a_s.first) |-> !a_odd);

endmodule

// File: rtl/pyr_lvl_interp.sv
module pyr_lvl_interp
    import pyr_lvl_pkg::*;
#(
    parameter int PRED_STAGES = 5
)(
    input  logic  clk,
    input  logic  rst,
    input  band_t band,
    output word_t pred
);

    pix_t  q_prev;
    pix_t  q_hold;
    logic  pend;
    word_t d_out;

    // stage D: expand one coefficient into two predictions
    always_ff @(posedge clk) begin
        if (rst) begin
            q_prev <= '0;
            q_hold <= '0;
            pend   <= 1'b0;
            d_out  <= '0;
        end else if (band.valid) begin
            d_out.valid <= 1'b1;
            d_out.pix   <= band.first ? band.coef : mid_up(q_prev, band.coef);
            q_prev      <= band.coef;
            q_hold      <= band.coef;
            pend        <= 1'b1;
        end else if (pend) begin
            d_out.valid <= 1'b1;
            d_out.pix   <= q_hold;
            pend        <= 1'b0;
        end else begin
            d_out.valid <= 1'b0;
        end
    end

    // a new coefficient must not arrive while the odd prediction waits
    assert_no_overlap_R8: assert property (@(posedge clk) disable iff (rst)
        band.valid |-> !pend);

    // retiming stages after the expander
    generate
        if (PRED_STAGES == 0) begin : g_direct
            assign pred = d_out;
        end else begin : g_retime
            word_t pipe [PRED_STAGES];
            always_ff @(posedge clk) begin
                if (rst) begin
                    for (int i = 0; i < PRED_STAGES; i++) pipe[i] <= '0;
                end else begin
                    pipe[0] <= d_out;
                    for (int i = 1; i < PRED_STAGES; i++) pipe[i] <= pipe[i-1];
                end
            end
            assign pred = pipe[PRED_STAGES-1];
        end
    endgenerate

endmodule

// File: rtl/pyr_lvl_align.sv
module pyr_lvl_align
    import pyr_lvl_pkg::*;
#(
    parameter int DEPTH = 10
)(
    input  logic  clk,
    input  logic  rst,
    input  logic  in_valid,
    input  pix_t  in_pixel,
    output word_t aligned
);

    localparam int LAST = DEPTH - 1;

    word_t line [DEPTH];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < DEPTH; i++) line[i] <= '0;
        end else begin
            line[0].valid <= in_valid;
            line[0].pix   <= in_pixel;
            for (int i = 1; i < DEPTH; i++) line[i] <= line[i-1];
        end
    end

    assign aligned = line[LAST];

endmodule

// File: rtl/pyr_residual_level.sv
module pyr_residual_level
    import pyr_lvl_pkg::*;
#(
    parameter int PRED_STAGES = 5,
    parameter int ALIGN_DEPTH = 10
)(
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    in_valid,
    input  logic                    in_line_start,
    input  logic [7:0]              in_pixel,
    output logic                    lo_valid,
    output logic [7:0]              lo_coef,
    output logic                    hf_valid,
    output logic signed [11:0]      hf_resid
);

    band_t band;
    word_t pred;
    word_t aligned;

    pyr_lvl_decim u_decim (
        .clk           (clk),
        .rst           (rst),
        .in_valid      (in_valid),
        .in_line_start (in_line_start),
        .in_pixel      (in_pixel),
        .band          (band)
    );

    pyr_lvl_interp #(.PRED_STAGES(PRED_STAGES)) u_interp (
        .clk  (clk),
        .rst  (rst),
        .band (band),
        .pred (pred)
    );

    pyr_lvl_align #(.DEPTH(ALIGN_DEPTH)) u_align (
        .clk      (clk),
        .rst      (rst),
        .in_valid (in_valid),
        .in_pixel (in_pixel),
        .aligned  (aligned)
    );

    assign lo_valid = band.valid;
    assign lo_coef  = band.coef;

    // subtractor stage
    always_ff @(posedge clk) begin
        if (rst) begin
            hf_valid <= 1'b0;
            hf_resid <= '0;
        end else begin
            hf_valid <= aligned.valid;
            hf_resid <= diff_of(aligned.pix, pred.pix);
        end
    end

    // the delayed original and its prediction arrive together
    assert_align_lock_R6: assert property (@(posedge clk) disable iff (rst)
        aligned.valid == pred.valid);

    assert_resid_range_R4: assert property (@(posedge clk) disable iff (rst)
        hf_valid |-> (hf_resid >= -12'sd255 && hf_resid <= 12'sd255));

    assert_lo_spacing_R2: assert property (@(posedge clk) disable iff (rst)
        lo_valid |=> !lo_valid);

    assert_idle_quiet_R9: assert property (@(posedge clk)
        $past(rst) |-> (!lo_valid && !hf_valid));

endmodule

// File: tb/sim_pyr_residual_level.sv
module sim_pyr_residual_level;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              in_valid = 1'b0;
    logic              in_line_start = 1'b0;
    logic [7:0]        in_pixel = '0;
    logic              lo_valid;
    logic [7:0]        lo_coef;
    logic              hf_valid;
    logic signed [11:0] hf_resid;

    always #2 clk = ~clk;   // 250 MHz

    pyr_residual_level u0 (
        .clk           (clk),
        .rst           (rst),
        .in_valid      (in_valid),
        .in_line_start (in_line_start),
        .in_pixel      (in_pixel),
        .lo_valid      (lo_valid),
        .lo_coef       (lo_coef),
        .hf_valid      (hf_valid),
        .hf_resid      (hf_resid)
    );

    typedef struct { int val; int cyc; } exp_t;
    exp_t lo_q[$];
    exp_t hf_q[$];

    int total = 0;
    int bad = 0;
    int cyc = 0;
    int lo_seen = 0;
    int lo_sent = 0;
    int streak = 0;
    int max_streak = 0;
    logic prev_lo = 1'b0;
    bit [31:0] seed_r = 32'h1234_5678;

    always @(posedge clk) cyc <= cyc + 1;

    task automatic check(input bit ok, input string what, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", what, act, exp);
        end
    endtask

    // monitor: pops expected items as outputs appear
    always @(negedge clk) begin
        if (!rst) begin
            if (lo_valid) begin
                check(!prev_lo, "R2 back-to-back lo_valid", 1, 0);
                lo_seen++;
                if (lo_q.size() == 0) begin
                    check(1'b0, "R10 unexpected low coefficient", int'(lo_coef), -1);
                end else begin
                    exp_t e;
                    e = lo_q.pop_front();
                    check(int'(lo_coef) == e.val, "R1 low coefficient", int'(lo_coef), e.val);
                    check(cyc == e.cyc, "R1 low coefficient cycle", cyc, e.cyc);
                end
            end
            prev_lo = lo_valid;
            if (hf_valid) begin
                streak++;
                if (streak > max_streak) max_streak = streak;
                if (hf_q.size() == 0) begin
                    check(1'b0, "R10 unexpected residual", int'(hf_resid), -1);
                end else begin
                    exp_t e;
                    e = hf_q.pop_front();
                    check(int'(hf_resid) == e.val, "R3/R4 residual value", int'(hf_resid), e.val);
                    check(cyc == e.cyc, "R5/R6 residual cycle", cyc, e.cyc);
                end
            end else begin
                streak = 0;
            end
        end
    end

    function automatic int pick(int kind, int n, int s);
        case (kind)
            0: return (n * 9 + s) & 255;
            1: return s & 255;
            2: return (n & 1) ? 255 : 0;
            default: begin
                seed_r = seed_r * 32'd1103515245 + 32'd12345;
                return int'(seed_r[23:16]);
            end
        endcase
    endfunction

    // driver: sends one line and pushes its expected results (zero history, R7)
    task automatic send_line(input int len, input int kind, input int s);
        int xs[0:127];
        int cp[0:127];
        int qs[0:63];
        for (int n = 0; n < len; n++) begin
            @(negedge clk);
            xs[n] = pick(kind, n, s);
            in_valid      = 1'b1;
            in_line_start = (n == 0);
            in_pixel      = 8'(xs[n]);
            cp[n] = cyc + 1;
            if (n & 1) begin
                int k, q, pe, older;
                exp_t e;
                k = n / 2;
                older = (n >= 2) ? xs[n-2] : 0;
                q = (xs[n] + 2 * xs[n-1] + older + 2) >> 2;
                qs[k] = q;
                e.val = q; e.cyc = cp[n] + 2;
                lo_q.push_back(e);
                lo_sent++;
                pe = (k == 0) ? q : ((qs[k-1] + q + 1) >> 1);
                e.val = xs[n-1] - pe; e.cyc = cp[n-1] + 10;
                hf_q.push_back(e);
                e.val = xs[n] - q; e.cyc = cp[n] + 10;
                hf_q.push_back(e);
            end
        end
    endtask

    // idle cycles with garbage on the ignored inputs (R10)
    task automatic idle(input int cycles);
        for (int i = 0; i < cycles; i++) begin
            @(negedge clk);
            in_valid      = 1'b0;
            in_line_start = 1'b1;
            in_pixel      = 8'hA5;
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check(!lo_valid && !hf_valid, "R9 outputs during reset", int'(lo_valid) + int'(hf_valid), 0);
        rst = 1'b0;
        @(negedge clk);
        check(!lo_valid && !hf_valid, "R9 outputs after reset", int'(lo_valid) + int'(hf_valid), 0);

        send_line(16, 0, 3);      // ramp
        idle(4);
        send_line(8, 1, 255);     // flat bright
        idle(3);
        send_line(12, 2, 0);      // extreme alternation, largest residuals (R4)
        idle(15);
        max_streak = 0;
        // R8: back-to-back group of 20 + 2 + 14 samples
        send_line(20, 3, 0);
        send_line(2, 2, 0);
        send_line(14, 3, 0);
        idle(20);
        check(max_streak == 36, "R8 consecutive residual run", max_streak, 36);
        // R7: a dark line right after a bright-ending line, with no gap
        send_line(10, 1, 250);
        send_line(10, 1, 0);
        send_line(6, 0, 200);
        idle(30);
        check(lo_q.size() == 0 && hf_q.size() == 0, "R10 missing outputs",
              lo_q.size() + hf_q.size(), 0);
        check(lo_seen == lo_sent, "R2 coefficient count", lo_seen, lo_sent);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog R8 run did not end actual=%0d expected=%0d", cyc, 20000);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule